// File: doc/BRIEF.md
# Timestamp Compare Timed Output

This block drives one output pin from a free-running 64-bit time count. Software programs a 64-bit target time through a small register window. When the time count reaches that target, the block changes the pin level and adds one to an event counter. The pin can be set high, set low, or inverted on each event, depending on the selected edge mode.

The 64-bit target is written as two 32-bit halves. The upper half is held aside until the lower half arrives, and the whole value then takes effect in one step. A target of zero never matches, so software can write zero to park the unit while it changes other settings. The path from match to pin has a fixed two-cycle latency, so software programs the wanted time minus two. Each committed target fires at most once. Clearing enable, selecting input direction or choosing the reserved edge mode all stop events, and the pin keeps its last level.

Top module: `tcmp_timed_out`

## Requirements
- R1: After reset the control word, both compare halves and the event count read as zero. The pin reads low and the pin drive enable `pin_oe` is high.
- R2: Control at offset 0x00 holds enable in bit 0 and direction in bit 1 (1 = input). Bits 3:2 hold the edge mode: 0 rising, 1 falling, 2 toggle, 3 reserved. A read returns bits 3:0 as written and zero above them. `pin_oe` is the inverse of the direction bit.
- R3: A write to offset 0x14 stores the upper compare half as pending, and this does not change what 0x10 or 0x14 read. A write to offset 0x10 commits {pending upper half, written lower half} as the new compare value. Reads of 0x10 and 0x14 return the lower and upper halves of the committed value.
- R4: A committed compare value of zero never produces an event, even when the time count passes zero.
- R5: When the time count sampled on a clock edge equals the compare value, the pin and the event count change on the second following clock edge.
- R6: On an event, rising mode drives the pin high, falling mode drives it low, and toggle mode inverts it.
- R7: The event count at offset 0x30 is 32 bits wide and increases by one per event. Writes to 0x30 have no effect.
- R8: A committed compare value produces at most one event. If the time count passes the same value again, nothing happens until a new low-half write.
- R9: While enable is 0, direction is 1 or the mode is 3, no event occurs and the pin holds its level. This includes a match already in the latency pipeline when the gate closes.
- R10: Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the time count is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_cnt | input | 64 | Free-running time count |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timed_out | output | 1 | Timed output pin level |
| pin_oe | output | 1 | Pin drive enable, high in output direction |

## Verification
The assertions assume that the time count is sampled once per clock edge, and that each cycle with `bus_wr` high is exactly one register write to the offset on `bus_addr`. They also assume no compare commit lands in the same cycle as a match it would affect. The bench holds a write strobe for one clock only, and it issues every commit well before the target comes around. It rewinds the time count only through a load made when no match is in flight. Rewinds are used on purpose to pass a target a second time and to cross zero.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE   = 2'd0,
    EDGE_FALL   = 2'd1,
    EDGE_TOGGLE = 2'd2,
    EDGE_RSVD   = 2'd3
  } edge_mode_e;

  typedef struct packed {
    edge_mode_e mode;
    logic       dir_in;
    logic       en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_CMP_LO = 8'h10;
  localparam logic [7:0] OFS_CMP_HI = 8'h14;
  localparam logic [7:0] OFS_EVT    = 8'h30;

endpackage

// File: rtl/tcmp_regs.sv
module tcmp_regs
  import tcmp_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 64,
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] evt_count,
  output ctrl_t         ctrl,
  output logic [TW-1:0] cmp_val,
  output logic          commit,
  output logic [DW-1:0] rdata
);

  localparam int unsigned HW = TW / 2;

  ctrl_t         ctrl_q, ctrl_d;
  logic [HW-1:0] pend_hi_q, pend_hi_d;
  logic [TW-1:0] cmp_q, cmp_d;
  logic          sel_ctrl, sel_lo, sel_hi;
  logic          ctrl_ce, lo_ce, hi_ce;

  always_comb begin
    sel_ctrl = (addr == AW'(OFS_CTRL));
    sel_lo   = (addr == AW'(OFS_CMP_LO));
    sel_hi   = (addr == AW'(OFS_CMP_HI));
    ctrl_ce  = wr && sel_ctrl;
    lo_ce    = wr && sel_lo;
    hi_ce    = wr && sel_hi;
  end

  always_comb begin
    ctrl_d    = ctrl_q;
    pend_hi_d = pend_hi_q;
    cmp_d     = cmp_q;
    if (ctrl_ce) begin
      ctrl_d.en     = wdata[0];
      ctrl_d.dir_in = wdata[1];
      ctrl_d.mode   = edge_mode_e'(wdata[3:2]);
    end
    if (hi_ce) begin
      pend_hi_d = wdata[HW-1:0];
    end
    if (lo_ce) begin
      cmp_d = {pend_hi_q, wdata[HW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      pend_hi_q <= '0;
      cmp_q     <= '0;
    end else begin
      if (ctrl_ce) ctrl_q    <= ctrl_d;
      if (hi_ce)   pend_hi_q <= pend_hi_d;
      if (lo_ce)   cmp_q     <= cmp_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)                    rdata = DW'(ctrl_q);
    else if (sel_lo)                 rdata = DW'(cmp_q[HW-1:0]);
    else if (sel_hi)                 rdata = DW'(cmp_q[TW-1:HW]);
    else if (addr == AW'(OFS_EVT))   rdata = DW'(evt_count);
  end

  assign ctrl    = ctrl_q;
  assign cmp_val = cmp_q;
  assign commit  = lo_ce;

  // R3
  cmp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == AW'(OFS_CMP_LO)) |=>
      cmp_q == {$past(pend_hi_q), $past(wdata[HW-1:0])});

  // R3
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == AW'(OFS_CMP_LO)) |=> $stable(cmp_q));

endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
  parameter int unsigned TW  = 64,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_cnt,
  input  logic [TW-1:0] cmp_val,
  input  logic          commit,
  input  logic          gate_ok,
  output logic          fire_req
);

  localparam int unsigned PD = (LAT > 1) ? LAT - 1 : 1;

  logic          armed_q, armed_d;
  logic          hit;
  logic [PD-1:0] pipe_q, pipe_d;

  always_comb begin
    hit = armed_q && gate_ok && (cmp_val != '0) && (time_cnt == cmp_val);
    armed_d = armed_q;
    if (hit)    armed_d = 1'b0;
    if (commit) armed_d = 1'b1;
  end

  generate
    if (PD == 1) begin : g_single
      always_comb pipe_d = hit;
    end else begin : g_chain
      always_comb pipe_d = {pipe_q[PD-2:0], hit};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pipe_q  <= '0;
    end else begin
      armed_q <= armed_d;
      pipe_q  <= pipe_d;
    end
  end

  assign fire_req = pipe_q[PD-1];

  // R8
  once_per_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !commit) |=> !armed_q);

endmodule

// File: rtl/tcmp_edge.sv
module tcmp_edge
  import tcmp_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_req,
  input  logic          gate_ok,
  input  edge_mode_e    mode,
  output logic          level,
  output logic [CW-1:0] evt_count
);

  logic          fire;
  logic          level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    fire    = fire_req && gate_ok;
    level_d = level_q;
    unique case (mode)
      EDGE_RISE:   level_d = 1'b1;
      EDGE_FALL:   level_d = 1'b0;
      EDGE_TOGGLE: level_d = ~level_q;
      default:     level_d = level_q;
    endcase
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (fire) begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level     = level_q;
  assign evt_count = cnt_q;

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_req && gate_ok) |=> ($stable(level_q) && $stable(cnt_q)));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_req && gate_ok) |=> cnt_q == $past(cnt_q) + CW'(1));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_req && gate_ok && mode == EDGE_TOGGLE) |=> level_q != $past(level_q));

  // R6
  rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_req && gate_ok && mode == EDGE_RISE) |=> level_q);

endmodule

// File: rtl/tcmp_timed_out.sv
module tcmp_timed_out
  import tcmp_pkg::*;
#(
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned TW  = 64,
  parameter int unsigned CW  = 32,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_cnt,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          timed_out,
  output logic          pin_oe
);

  logic          rst_meta_q, rst_q;
  ctrl_t         ctrl;
  logic [TW-1:0] cmp_val;
  logic          commit;
  logic          gate_ok;
  logic          fire_req;
  logic [CW-1:0] evt_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  tcmp_regs #(.AW(AW), .DW(DW), .TW(TW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .evt_count (evt_count),
    .ctrl      (ctrl),
    .cmp_val   (cmp_val),
    .commit    (commit),
    .rdata     (bus_rdata)
  );

  always_comb gate_ok = ctrl.en && !ctrl.dir_in && (ctrl.mode != EDGE_RSVD);

  tcmp_match #(.TW(TW), .LAT(LAT)) u_match (
    .clk      (clk),
    .rst_n    (rst_q),
    .time_cnt (time_cnt),
    .cmp_val  (cmp_val),
    .commit   (commit),
    .gate_ok  (gate_ok),
    .fire_req (fire_req)
  );

  tcmp_edge #(.CW(CW)) u_edge (
    .clk       (clk),
    .rst_n     (rst_q),
    .fire_req  (fire_req),
    .gate_ok   (gate_ok),
    .mode      (ctrl.mode),
    .level     (timed_out),
    .evt_count (evt_count)
  );

  assign pin_oe = ~ctrl.dir_in;

  // R4
  zero_never_fires_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cmp_val == '0 && $stable(cmp_val) && !commit) |=> $stable(evt_count));

  // R2
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_q)
    pin_oe != ctrl.dir_in);

endmodule

// File: tb/tcmp_timed_out_test.sv
module tcmp_timed_out_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tcnt = 64'h0000_0001_FFFF_FF00;
  logic        tload = 1'b0;
  logic [63:0] tload_val = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        timed_out;
  logic        pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (tload) tcnt <= tload_val;
    else       tcnt <= tcnt + 64'd1;
  end

  tcmp_timed_out uut (
    .clk(clk), .rst_n(rst_n), .time_cnt(tcnt), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timed_out(timed_out), .pin_oe(pin_oe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_cmp(input logic [63:0] v);
    wr_reg(8'h14, v[63:32]);
    wr_reg(8'h10, v[31:0]);
  endtask

  task automatic wait_for(input logic [63:0] v);
    while (tcnt != v) step();
  endtask

  task automatic load_time(input logic [63:0] v);
    tload = 1'b1; tload_val = v;
    step();
    tload = 1'b0;
  endtask

  function automatic logic next_lvl(input logic [1:0] mode, input logic cur);
    case (mode)
      2'd0: return 1'b1;
      2'd1: return 1'b0;
      2'd2: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic fires(input logic [3:0] c, input logic [63:0] v);
    return c[0] && !c[1] && (c[3:2] != 2'd3) && (v != 64'd0);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    logic [31:0] cnt;
    logic        lvl;
    void'($urandom(32'd4242));

    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    rd_reg(8'h00, d); check("R1 ctrl", d, 0);
    rd_reg(8'h10, d); check("R1 cmp lo", d, 0);
    rd_reg(8'h14, d); check("R1 cmp hi", d, 0);
    rd_reg(8'h30, d); check("R1 evt", d, 0);
    check("R1 pin", timed_out, 0);
    check("R1 oe", pin_oe, 1);

    // R2 control readback and drive enable
    wr_reg(8'h00, 32'hFFFF_FFF6);
    rd_reg(8'h00, d); check("R2 ctrl readback", d, 32'h6);
    check("R2 oe input dir", pin_oe, 0);
    wr_reg(8'h00, 32'h0);
    check("R2 oe output dir", pin_oe, 1);

    // R10 unmapped offset
    rd_reg(8'h20, d); check("R10 unmapped", d, 0);

    // R3 pending upper half invisible
    wr_reg(8'h14, 32'h0000_00A5);
    rd_reg(8'h14, d); check("R3 hi pending hidden", d, 0);
    rd_reg(8'h10, d); check("R3 lo unchanged", d, 0);
    wr_reg(8'h10, 32'h1234_5678);
    rd_reg(8'h14, d); check("R3 hi committed", d, 32'hA5);
    rd_reg(8'h10, d); check("R3 lo committed", d, 32'h1234_5678);

    // R5 latency with rising mode, target crossing the half boundary
    wr_reg(8'h00, 32'h1);
    t = 64'h0000_0002_0000_0004;
    set_cmp(t);
    wait_for(t + 1);
    check("R5 pin before edge", timed_out, 0);
    rd_reg(8'h30, d); check("R5 evt before edge", d, 0);
    step();
    check("R5 pin at edge", timed_out, 1);
    check("R6 rise drives high", timed_out, 1);
    rd_reg(8'h30, d); check("R7 evt after one", d, 1);

    // R8 passing the same target again does nothing
    load_time(t - 6);
    repeat (12) step();
    rd_reg(8'h30, d); check("R8 no second event", d, 1);
    check("R8 pin held", timed_out, 1);

    // R6 toggle and falling
    wr_reg(8'h00, 32'h9);
    t = tcnt + 20; set_cmp(t); wait_for(t + 3);
    check("R6 toggle to low", timed_out, 0);
    t = tcnt + 20; set_cmp(t); wait_for(t + 3);
    check("R6 toggle to high", timed_out, 1);
    wr_reg(8'h00, 32'h5);
    t = tcnt + 20; set_cmp(t); wait_for(t + 3);
    check("R6 fall drives low", timed_out, 0);
    rd_reg(8'h30, d); check("R7 evt after four", d, 4);

    // R4 zero target never fires, even crossing zero
    wr_reg(8'h00, 32'h9);
    set_cmp(64'd0);
    load_time(64'hFFFF_FFFF_FFFF_FFF8);
    repeat (16) step();
    rd_reg(8'h30, d); check("R4 zero no event", d, 4);
    check("R4 pin held", timed_out, 0);
    load_time(64'h0000_0003_0000_0000);

    // R9 enable cleared while a match is in the pipeline
    t = tcnt + 20; set_cmp(t); wait_for(t);
    wr_reg(8'h00, 32'h8);
    repeat (6) step();
    rd_reg(8'h30, d); check("R9 in-flight dropped", d, 4);
    check("R9 pin held after disable", timed_out, 0);

    // R9 input direction and reserved mode
    wr_reg(8'h00, 32'hB);
    t = tcnt + 20; set_cmp(t); wait_for(t + 4);
    rd_reg(8'h30, d); check("R9 input dir no event", d, 4);
    wr_reg(8'h00, 32'hD);
    t = tcnt + 20; set_cmp(t); wait_for(t + 4);
    rd_reg(8'h30, d); check("R9 reserved mode no event", d, 4);
    check("R9 reserved pin held", timed_out, 0);

    // R7 write to event counter ignored
    wr_reg(8'h30, 32'h0000_1234);
    rd_reg(8'h30, d); check("R7 write ignored", d, 4);

    // Random mix
    cnt = 4;
    lvl = timed_out;
    for (int i = 0; i < 40; i++) begin
      logic [3:0]  c;
      logic [31:0] ofs;
      c[3:2] = 2'($urandom % 4);
      c[0]   = ($urandom % 5) != 0;
      c[1]   = ($urandom % 6) == 0;
      ofs    = 32'd8 + ($urandom % 40);
      t      = (($urandom % 8) == 0) ? 64'd0 : tcnt + 64'(ofs);
      wr_reg(8'h00, {28'd0, c});
      set_cmp(t);
      repeat (ofs + 4) step();
      if (fires(c, t)) begin
        cnt = cnt + 1;
        lvl = next_lvl(c[3:2], lvl);
      end
      rd_reg(8'h30, d); check("R7 random evt", d, cnt);
      check("R6 R9 random pin", timed_out, lvl);
    end

    finish_run();
  end

endmodule